// File: doc/BRIEF.md
# Register Value Queue Checker

This block sits between a leading out-of-order core and a lagging in-order checker core that runs the same program. The leading core pushes every register result it produces into a queue, in program order, with its destination register tag. The checker core pops entries and uses the queued values as its source operands instead of reading its own register file. Because the queued values are correct unless a fault has occurred, the checker core never stalls on data dependences.

Each popped entry is also kept in a small pending buffer inside the block until the checker core commits the matching instruction. At commit the checker core presents its own recomputed tag and result. The block compares them with the oldest pending entry. The first disagreement raises a sticky fault flag and records the commit's ordinal and the kind of mismatch. The block also exports the slack, which is the number of entries pushed but not yet popped.

Top module: `rvq_checker`

## Requirements
- R1: After a synchronous active-high reset, `slack` is 0, `lead_ready` is 1, `trail_avail` is 0, `trail_rsp_valid` is 0, `fault` is 0, `fault_kind` is 0 and `fail_idx` is 0.
- R2: A push is accepted on a rising edge where `lead_valid` and `lead_ready` are both high. `lead_ready` is low exactly while `slack` equals DEPTH. A push offered while `lead_ready` is low is dropped and never appears at the pop side.
- R3: A pop accepted on a rising edge (`trail_pop` and `trail_avail` high) drives `trail_rsp_valid` high for the following cycle, with that entry's tag and value. Entries leave in the order in which they were accepted.
- R4: `trail_avail` is low whenever `slack` is 0. A pop request made while `trail_avail` is low has no effect.
- R5: `slack` rises by one on each accepted push and falls by one on each accepted pop. It is unchanged when both or neither occur in the same cycle, and it never exceeds DEPTH.
- R6: An accepted commit (`cmt_valid` high while at least one popped entry awaits commit) retires the oldest such entry. When tag and value both match, `fault` stays low.
- R7: The first accepted commit whose tag or value differs from the retired entry sets `fault` on the following cycle. In the same cycle it sets `fail_idx` to the zero-based ordinal of that commit among accepted commits since reset, and sets `fault_kind` to 2 for a tag mismatch (this takes precedence) or to 1 for a value-only mismatch. `fault` stays high until reset.
- R8: Mismatches after the first one change neither `fail_idx` nor `fault_kind`.
- R9: `cmt_valid` while no popped entry awaits commit is ignored: it raises no fault and does not advance the commit ordinal.
- R10: At most PEND_DEPTH popped entries, counting one whose response is still in flight, may await commit. `trail_avail` is low while that limit is reached, even if `slack` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lead_valid | input | 1 | Leading core offers a result |
| lead_tag | input | TAG_W | Destination register tag of the offered result |
| lead_value | input | DATA_W | Offered result value |
| lead_ready | output | 1 | Queue can accept a push |
| trail_pop | input | 1 | Checker core requests the next entry |
| trail_avail | output | 1 | A pop would be accepted |
| trail_rsp_valid | output | 1 | Popped entry is presented this cycle |
| trail_rsp_tag | output | TAG_W | Tag of the popped entry |
| trail_rsp_value | output | DATA_W | Value of the popped entry |
| cmt_valid | input | 1 | Checker core commits an instruction |
| cmt_tag | input | TAG_W | Recomputed destination tag |
| cmt_value | input | DATA_W | Recomputed result |
| slack | output | $clog2(DEPTH+1) | Entries pushed but not yet popped |
| fault | output | 1 | Sticky mismatch flag |
| fault_kind | output | 2 | 0 none, 1 value mismatch, 2 tag mismatch |
| fail_idx | output | IDX_W | Ordinal of the first mismatching commit |

## Verification
The assertions check on every cycle that the slack counter stays within the queue depth, that no push is taken when full and no pop when empty, that every accepted pop yields a response one cycle later, that the pending buffer is never overrun, and that the fault flag and its record are held once set. Only the bench scenarios can show that data emerges in push order with the right values, that dropped pushes and idle commits leave no trace, and that the recorded ordinal and mismatch kind are the right ones. The bench covers a full queue, a full pending buffer and injected tag and value corruptions.

// File: rtl/rvq_pkg.sv
package rvq_pkg;

  localparam int RVQ_TAG_W   = 5;
  localparam int RVQ_DATA_W  = 32;
  localparam int RVQ_DEPTH   = 64;
  localparam int RVQ_PEND    = 4;
  localparam int RVQ_IDX_W   = 16;

  typedef enum logic [1:0] {
    FK_NONE  = 2'd0,
    FK_VALUE = 2'd1,
    FK_TAG   = 2'd2
  } fault_kind_e;

  function automatic int clog2_min1(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/rvq_slack.sv
module rvq_slack #(
  parameter int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);

  logic [CNT_W-1:0] count_n;

  always_comb begin
    unique case ({inc, dec})
      2'b10:   count_n = count + 1'b1;
      2'b01:   count_n = count - 1'b1;
      default: count_n = count;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      full  <= 1'b0;
      empty <= 1'b1;
    end else begin
      count <= count_n;
      full  <= (count_n == CNT_W'(DEPTH));
      empty <= (count_n == '0);
    end
  end

  AST_SLACK_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH)); // R5

endmodule

// File: rtl/rvq_store.sv
module rvq_store #(
  parameter int DEPTH   = 64,
  parameter int ENTRY_W = 37
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ENTRY_W-1:0] wr_data,
  input  logic               rd_en,
  output logic [ENTRY_W-1:0] rd_data,
  output logic               rd_valid
);

  localparam int PTR_W = rvq_pkg::clog2_min1(DEPTH);

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]   wr_ptr;
  logic [PTR_W-1:0]   rd_ptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // Storage array without reset so that it maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (wr_en) wr_ptr <= bump(wr_ptr);
      if (rd_en) rd_ptr <= bump(rd_ptr);
      rd_valid <= rd_en;
    end
  end

  AST_RSP_AFTER_POP: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid); // R3

endmodule

// File: rtl/rvq_compare.sv
module rvq_compare
  import rvq_pkg::*;
#(
  parameter int TAG_W      = 5,
  parameter int DATA_W     = 32,
  parameter int PEND_DEPTH = 4,
  parameter int IDX_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [DATA_W-1:0] in_value,
  input  logic              cmt_valid,
  input  logic [TAG_W-1:0]  cmt_tag,
  input  logic [DATA_W-1:0] cmt_value,
  output logic              pend_room,
  output logic              fault,
  output logic [1:0]        fault_kind,
  output logic [IDX_W-1:0]  fail_idx
);

  localparam int PP_W = clog2_min1(PEND_DEPTH);
  localparam int PC_W = $clog2(PEND_DEPTH + 1);

  logic [TAG_W-1:0]  p_tag [PEND_DEPTH];
  logic [DATA_W-1:0] p_val [PEND_DEPTH];
  logic [PP_W-1:0]   p_wr;
  logic [PP_W-1:0]   p_rd;
  logic [PC_W-1:0]   p_cnt;
  logic [IDX_W-1:0]  seq;
  fault_kind_e       kind_q;

  logic              cmt_acc;
  logic              tag_bad;
  logic              val_bad;
  logic [PC_W:0]     occ;

  function automatic logic [PP_W-1:0] bump(input logic [PP_W-1:0] p);
    return (p == PP_W'(PEND_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign occ       = {1'b0, p_cnt} + {{PC_W{1'b0}}, in_valid};
  assign pend_room = (occ < (PC_W + 1)'(PEND_DEPTH));
  assign cmt_acc   = cmt_valid && (p_cnt != '0);
  assign tag_bad   = (p_tag[p_rd] != cmt_tag);
  assign val_bad   = (p_val[p_rd] != cmt_value);

  always_ff @(posedge clk) begin
    if (in_valid) begin
      p_tag[p_wr] <= in_tag;
      p_val[p_wr] <= in_value;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      p_wr  <= '0;
      p_rd  <= '0;
      p_cnt <= '0;
    end else begin
      if (in_valid) p_wr <= bump(p_wr);
      if (cmt_acc)  p_rd <= bump(p_rd);
      unique case ({in_valid, cmt_acc})
        2'b10:   p_cnt <= p_cnt + 1'b1;
        2'b01:   p_cnt <= p_cnt - 1'b1;
        default: p_cnt <= p_cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seq      <= '0;
      fault    <= 1'b0;
      kind_q   <= FK_NONE;
      fail_idx <= '0;
    end else if (cmt_acc) begin
      seq <= seq + 1'b1;
      if (!fault && (tag_bad || val_bad)) begin
        fault    <= 1'b1;
        fail_idx <= seq;
        kind_q   <= tag_bad ? FK_TAG : FK_VALUE;
      end
    end
  end

  assign fault_kind = kind_q;

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
    fault |=> fault); // R7
  AST_FIRST_ONLY: assert property (@(posedge clk) disable iff (rst)
    fault |=> ($stable(fail_idx) && $stable(fault_kind))); // R8
  AST_IDLE_COMMIT: assert property (@(posedge clk) disable iff (rst)
    (cmt_valid && (p_cnt == '0) && !fault) |=> !fault); // R9
  AST_PEND_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> (p_cnt < PC_W'(PEND_DEPTH))); // R10

endmodule

// File: rtl/rvq_checker.sv
module rvq_checker
  import rvq_pkg::*;
#(
  parameter int TAG_W      = RVQ_TAG_W,
  parameter int DATA_W     = RVQ_DATA_W,
  parameter int DEPTH      = RVQ_DEPTH,
  parameter int PEND_DEPTH = RVQ_PEND,
  parameter int IDX_W      = RVQ_IDX_W,
  localparam int SLACK_W   = $clog2(DEPTH + 1),
  localparam int ENTRY_W   = TAG_W + DATA_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lead_valid,
  input  logic [TAG_W-1:0]   lead_tag,
  input  logic [DATA_W-1:0]  lead_value,
  output logic               lead_ready,
  input  logic               trail_pop,
  output logic               trail_avail,
  output logic               trail_rsp_valid,
  output logic [TAG_W-1:0]   trail_rsp_tag,
  output logic [DATA_W-1:0]  trail_rsp_value,
  input  logic               cmt_valid,
  input  logic [TAG_W-1:0]   cmt_tag,
  input  logic [DATA_W-1:0]  cmt_value,
  output logic [SLACK_W-1:0] slack,
  output logic               fault,
  output logic [1:0]         fault_kind,
  output logic [IDX_W-1:0]   fail_idx
);

  logic               push;
  logic               pop;
  logic               q_full;
  logic               q_empty;
  logic               pend_room;
  logic [ENTRY_W-1:0] rd_entry;

  assign lead_ready  = !q_full;
  assign trail_avail = !q_empty && pend_room;
  assign push        = lead_valid && lead_ready;
  assign pop         = trail_pop && trail_avail;

  rvq_slack #(.DEPTH(DEPTH)) i_slack (
    .clk   (clk),
    .rst   (rst),
    .inc   (push),
    .dec   (pop),
    .count (slack),
    .full  (q_full),
    .empty (q_empty)
  );

  rvq_store #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) i_store (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (push),
    .wr_data  ({lead_tag, lead_value}),
    .rd_en    (pop),
    .rd_data  (rd_entry),
    .rd_valid (trail_rsp_valid)
  );

  assign trail_rsp_tag   = rd_entry[ENTRY_W-1:DATA_W];
  assign trail_rsp_value = rd_entry[DATA_W-1:0];

  rvq_compare #(
    .TAG_W(TAG_W), .DATA_W(DATA_W), .PEND_DEPTH(PEND_DEPTH), .IDX_W(IDX_W)
  ) i_compare (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (trail_rsp_valid),
    .in_tag     (trail_rsp_tag),
    .in_value   (trail_rsp_value),
    .cmt_valid  (cmt_valid),
    .cmt_tag    (cmt_tag),
    .cmt_value  (cmt_value),
    .pend_room  (pend_room),
    .fault      (fault),
    .fault_kind (fault_kind),
    .fail_idx   (fail_idx)
  );

  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (rst)
    push |-> (slack < SLACK_W'(DEPTH))); // R2
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
    pop |-> (slack != '0)); // R4
  AST_SLACK_UP: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |=> (slack == $past(slack) + 1'b1)); // R5
  AST_SLACK_DOWN: assert property (@(posedge clk) disable iff (rst)
    (pop && !push) |=> (slack == $past(slack) - 1'b1)); // R5

endmodule

// File: tb/test_rvq_checker.sv
module test_rvq_checker;
  import rvq_pkg::*;

  localparam int TAG_W = RVQ_TAG_W;
  localparam int DATA_W = RVQ_DATA_W;
  localparam int DEPTH = RVQ_DEPTH;
  localparam int PD = RVQ_PEND;
  localparam int IDX_W = RVQ_IDX_W;
  localparam int SLACK_W = $clog2(DEPTH + 1);

  typedef struct packed {
    logic [TAG_W-1:0]  t;
    logic [DATA_W-1:0] v;
  } ent_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lead_valid = 1'b0, trail_pop = 1'b0, cmt_valid = 1'b0;
  logic [TAG_W-1:0] lead_tag = '0, cmt_tag = '0;
  logic [DATA_W-1:0] lead_value = '0, cmt_value = '0;
  logic lead_ready, trail_avail, trail_rsp_valid, fault;
  logic [TAG_W-1:0] trail_rsp_tag;
  logic [DATA_W-1:0] trail_rsp_value;
  logic [SLACK_W-1:0] slack;
  logic [1:0] fault_kind;
  logic [IDX_W-1:0] fail_idx;

  rvq_checker i_rvq_checker (
    .clk(clk), .rst(rst),
    .lead_valid(lead_valid), .lead_tag(lead_tag), .lead_value(lead_value),
    .lead_ready(lead_ready),
    .trail_pop(trail_pop), .trail_avail(trail_avail),
    .trail_rsp_valid(trail_rsp_valid), .trail_rsp_tag(trail_rsp_tag),
    .trail_rsp_value(trail_rsp_value),
    .cmt_valid(cmt_valid), .cmt_tag(cmt_tag), .cmt_value(cmt_value),
    .slack(slack), .fault(fault), .fault_kind(fault_kind), .fail_idx(fail_idx)
  );

  always #10 clk = ~clk;

  ent_t m_q[$];
  ent_t m_pend[$];
  bit m_rv;
  ent_t m_rent;
  int unsigned m_seq;
  bit m_fault;
  logic [IDX_W-1:0] m_idx;
  logic [1:0] m_kind;
  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_ready();
    return m_q.size() < DEPTH;
  endfunction

  function automatic bit pend_full();
    return (m_pend.size() + int'(m_rv)) >= PD;
  endfunction

  function automatic bit exp_avail();
    return (m_q.size() > 0) && !pend_full();
  endfunction

  function automatic ent_t rnd_ent();
    ent_t e;
    e.t = TAG_W'($urandom);
    e.v = $urandom;
    return e;
  endfunction

  function automatic ent_t good_commit();
    if (m_pend.size() > 0) return m_pend[0];
    return rnd_ent();
  endfunction

  task automatic model_reset();
    m_q.delete();
    m_pend.delete();
    m_rv = 0;
    m_rent = '0;
    m_seq = 0;
    m_fault = 0;
    m_idx = '0;
    m_kind = 2'd0;
  endtask

  task automatic check_outputs();
    chk("R2 lead_ready", 64'(lead_ready), 64'(exp_ready()));
    if (m_q.size() > 0 && pend_full())
      chk("R10 trail_avail", 64'(trail_avail), 64'(exp_avail()));
    else
      chk("R4 trail_avail", 64'(trail_avail), 64'(exp_avail()));
    chk("R5 slack", 64'(slack), 64'(m_q.size()));
    chk("R3 rsp_valid", 64'(trail_rsp_valid), 64'(m_rv));
    if (m_rv) begin
      chk("R3 rsp_tag", 64'(trail_rsp_tag), 64'(m_rent.t));
      chk("R3 rsp_value", 64'(trail_rsp_value), 64'(m_rent.v));
    end
    chk("R7 fault", 64'(fault), 64'(m_fault));
    chk("R8 fail_idx", 64'(fail_idx), 64'(m_idx));
    chk("R8 fault_kind", 64'(fault_kind), 64'(m_kind));
  endtask

  task automatic step(input bit lv, input ent_t le, input bit tp, input bit cv, input ent_t ce);
    bit rdy;
    bit av;
    ent_t h;
    @(negedge clk);
    check_outputs();
    rdy = exp_ready();
    av = exp_avail();
    lead_valid = lv; lead_tag = le.t; lead_value = le.v;
    trail_pop = tp;
    cmt_valid = cv; cmt_tag = ce.t; cmt_value = ce.v;
    if (cv && m_pend.size() > 0) begin
      h = m_pend.pop_front();
      if (h != ce && !m_fault) begin
        m_fault = 1;
        m_idx = IDX_W'(m_seq);
        m_kind = (h.t != ce.t) ? 2'd2 : 2'd1;
      end
      m_seq++;
    end
    if (m_rv) m_pend.push_back(m_rent);
    m_rv = tp && av;
    if (m_rv) m_rent = m_q.pop_front();
    if (lv && rdy) m_q.push_back(le);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    lead_valid = 0; trail_pop = 0; cmt_valid = 0;
    repeat (3) @(negedge clk);
    model_reset();
    rst = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < 4 * DEPTH + 20; k++) begin
      if (m_q.size() == 0 && m_pend.size() == 0 && !m_rv) break;
      step(0, rnd_ent(), 1, 1, good_commit());
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog expired");
    finish_run();
  end

  initial begin
    ent_t e;
    void'($urandom(32'h5eed_0042));
    model_reset();
    do_reset();

    // R1: reset state
    @(negedge clk);
    chk("R1 slack", 64'(slack), 64'd0);
    chk("R1 lead_ready", 64'(lead_ready), 64'd1);
    chk("R1 trail_avail", 64'(trail_avail), 64'd0);
    chk("R1 rsp_valid", 64'(trail_rsp_valid), 64'd0);
    chk("R1 fault", 64'(fault), 64'd0);
    chk("R1 fault_kind", 64'(fault_kind), 64'd0);
    chk("R1 fail_idx", 64'(fail_idx), 64'd0);

    // R2: fill beyond capacity; extra pushes must be dropped
    for (int k = 0; k < DEPTH + 4; k++) step(1, rnd_ent(), 0, 0, '0);
    chk("R2 slack at full", 64'(m_q.size()), 64'(DEPTH));
    // R3: popped order must match the accepted pushes only
    drain();
    chk("R6 no fault after full drain", 64'(fault), 64'd0);

    // Random traffic with correct commits (R3, R4, R5, R6)
    for (int k = 0; k < 3000; k++) begin
      int pp = (k < 1500) ? 70 : 35;
      step(($urandom % 100) < pp, rnd_ent(), ($urandom % 100) < 55,
           ($urandom % 100) < 50, good_commit());
    end
    drain();
    chk("R6 no fault after random run", 64'(fault), 64'd0);

    // R9: commit with nothing pending is ignored
    e = rnd_ent();
    step(0, e, 0, 1, e);
    step(0, e, 0, 1, e);

    // R10: pop without committing until the pending limit blocks pops
    for (int k = 0; k < 10; k++) step(1, rnd_ent(), 0, 0, '0);
    for (int k = 0; k < 12; k++) step(0, rnd_ent(), 1, 0, '0);
    chk("R10 pending held at limit", 64'(m_pend.size()), 64'(PD));

    // R7: first commit good, second has a bad tag
    step(0, rnd_ent(), 0, 1, good_commit());
    e = good_commit();
    e.t = ~e.t;
    step(0, rnd_ent(), 0, 1, e);
    step(0, rnd_ent(), 0, 0, '0);
    chk("R7 fault set", 64'(fault), 64'd1);
    chk("R7 tag kind", 64'(fault_kind), 64'd2);
    // R8: a later value mismatch leaves the record unchanged
    e = good_commit();
    e.v = e.v ^ 32'h1;
    step(0, rnd_ent(), 0, 1, e);
    step(0, rnd_ent(), 0, 0, '0);
    chk("R8 kind held", 64'(fault_kind), 64'd2);
    drain();

    // R1 again, then a value-only mismatch after some traffic (R7)
    do_reset();
    @(negedge clk);
    chk("R1 fault cleared", 64'(fault), 64'd0);
    chk("R1 fail_idx cleared", 64'(fail_idx), 64'd0);
    for (int k = 0; k < 200; k++)
      step(($urandom % 100) < 60, rnd_ent(), ($urandom % 100) < 60,
           ($urandom % 100) < 50, good_commit());
    for (int k = 0; k < 20; k++) begin
      if (m_pend.size() > 0) break;
      step(1, rnd_ent(), 1, 0, '0);
    end
    e = good_commit();
    e.v = ~e.v;
    step(0, rnd_ent(), 0, m_pend.size() > 0, e);
    step(0, rnd_ent(), 0, 0, '0);
    chk("R7 value kind", 64'(fault_kind), 64'd1);
    drain();

    finish_run();
  end

endmodule